// File: doc/BRIEF.md
# Four-Plane Planar Write Datapath

This block sits between a host and four byte-wide bitplane memories of a 16-colour planar display adapter. The host programs control registers through two index/data port pairs. One pair reaches the graphics-control registers and the other reaches the plane-enable register. The port pairs accept either a byte access to each port or a single 16-bit access to the index port that carries both the index and the value.

A CPU byte write to display memory fans out to all four planes at once. On the way, the byte is rotated right, planes can take a fixed all-ones or all-zeros colour byte in place of CPU data, and the result is combined with the plane latches by AND, OR or XOR. A per-bit mask then chooses between that result and the latched byte, and a per-plane enable decides which planes receive a strobe. A CPU read fetches all four plane bytes at one address, returns the selected plane one cycle later, and reloads the four latches that later writes use.

Top module: `vga_plane_writer`

## Requirements
- R1: After reset every control register and every latch is zero. No write strobe is raised while the plane-enable register is zero. With plane enables 4'hF and bit mask 8'hFF set, a CPU write stores its byte unchanged in all four planes.
- R2: Graphics registers are reached through index port 16'h03CE and data port 16'h03CF, and the plane-enable register through 16'h03C4 and 16'h03C5. A 16-bit write to an index port takes the index from bits 7:0 and writes bits 15:8 into that register. It also leaves the index set for later byte writes to the data port.
- R3: Graphics index 3 bits 2:0 give a right-rotate count applied to the CPU byte (count 0 leaves it unchanged; count 7 equals a left rotate by one).
- R4: Graphics index 1 holds a 4-bit per-plane substitute enable and index 0 a 4-bit colour. A plane whose enable bit is set uses 8'hFF if its colour bit is 1 and 8'h00 otherwise, instead of the rotated byte.
- R5: Graphics index 3 bits 4:3 select the operation against that plane's latch: 0 passes the operand, 1 ANDs, 2 ORs, 3 XORs.
- R6: Graphics index 8 is the bit mask. A 1 bit takes the processed value and a 0 bit takes the latch bit of the same plane.
- R7: During a CPU write, mem_we bit p equals bit p of the plane-enable register (sequencer index 2), and mem_addr equals cpu_addr. Plane p data lies in mem_wdata bits 8p+7:8p. No strobe is raised without a CPU write.
- R8: A CPU read (with no write in the same cycle) raises mem_re with mem_addr = cpu_addr. In the next cycle cpu_rvalid is 1 and cpu_rdata holds the plane chosen by graphics index 4 bits 1:0. At the end of that cycle all four latches load the returned bytes.
- R9: Graphics index 5 is stored, but the write path applies the processing above whatever write mode it holds.
- R10: Writes to an unassigned register index change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | Host port write strobe |
| io_port | input | 16 | Host port address |
| io_wide | input | 1 | 1 for a 16-bit port write |
| io_wdata | input | 16 | Host port write data |
| cpu_mem_wr | input | 1 | CPU display-memory byte write |
| cpu_mem_rd | input | 1 | CPU display-memory byte read |
| cpu_addr | input | ADDR_W | CPU display-memory address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Selected plane byte from a read |
| cpu_rvalid | output | 1 | cpu_rdata valid |
| mem_addr | output | ADDR_W | Shared plane-memory address |
| mem_we | output | 4 | Per-plane write strobes |
| mem_wdata | output | 32 | Per-plane write data, plane p at bits 8p+7:8p |
| mem_re | output | 1 | Plane-memory read request |
| mem_rdata | input | 32 | Plane bytes returned one cycle after mem_re |

## Verification
The hardest state to reach is a write whose result depends on distinct, known latch contents in each plane, because the latches can only be filled by a read. The bench first stores a different byte in each plane at one address, one plane at a time through the plane-enable register. It then reads that address back to load the latches, and runs every logical operation, substitution and mask case against those four differing bytes. A final masked write with an all-zero mask shows that the latch contents reached the planes unchanged.

// File: rtl/pw_pkg.sv
// Shared constants and types for the planar write datapath.
// Assumes four byte-wide planes; register indices are decoded on a full byte.
package pw_pkg;

    localparam int NUM_PLANES = 4;
    localparam int BYTE_W     = 8;
    localparam int BUS_W      = NUM_PLANES * BYTE_W;
    localparam int ROT_W      = $clog2(BYTE_W);
    localparam int PSEL_W     = $clog2(NUM_PLANES);

    // graphics-control register indices
    localparam logic [7:0] GIX_COLOUR = 8'd0;
    localparam logic [7:0] GIX_SUBEN  = 8'd1;
    localparam logic [7:0] GIX_ROTOP  = 8'd3;
    localparam logic [7:0] GIX_RDSEL  = 8'd4;
    localparam logic [7:0] GIX_MODE   = 8'd5;
    localparam logic [7:0] GIX_BMASK  = 8'd8;
    // sequencer register index
    localparam logic [7:0] SIX_PLANEN = 8'd2;

    typedef enum logic [1:0] {
        ALU_PASS = 2'd0,
        ALU_AND  = 2'd1,
        ALU_OR   = 2'd2,
        ALU_XOR  = 2'd3
    } alu_op_e;

    typedef struct packed {
        logic [NUM_PLANES-1:0] colour;
        logic [NUM_PLANES-1:0] sub_en;
        logic [ROT_W-1:0]      rot_cnt;
        alu_op_e               alu_op;
        logic [PSEL_W-1:0]     rd_plane;
        logic [1:0]            wr_mode;
        logic                  rd_mode;
        logic [BYTE_W-1:0]     bit_mask;
        logic [NUM_PLANES-1:0] plane_en;
    } ctrl_regs_t;

endpackage

// File: rtl/pw_port_decoder.sv
// Index/data port pair decoder.
// Turns host port writes into a single register write strobe with index and
// value. A 16-bit write to the index port sets the index and writes the value
// in one access; byte writes to the two ports reach the same result.
// Assumes the caller ignores indices it does not implement.
module pw_port_decoder #(
    parameter logic [15:0] IDX_PORT = 16'h03CE,
    parameter logic [15:0] DAT_PORT = 16'h03CF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        io_wr,
    input  logic [15:0] io_port,
    input  logic        io_wide,
    input  logic [15:0] io_wdata,
    output logic        reg_we,
    output logic [7:0]  reg_sel,
    output logic [7:0]  reg_val
);

    logic       hit_idx;
    logic       hit_dat;
    logic [7:0] index_q;

    // decode which of the two ports this access targets
    always_comb begin
        hit_idx = io_wr && (io_port == IDX_PORT);
        hit_dat = io_wr && (io_port == DAT_PORT);
    end

    // hold the current register index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= '0;
        end else if (hit_idx) begin
            index_q <= io_wdata[7:0];
        end
    end

    // form the register write: wide index access or data port byte
    always_comb begin
        reg_we  = (hit_idx && io_wide) || hit_dat;
        reg_sel = hit_idx ? io_wdata[7:0]  : index_q;
        reg_val = hit_idx ? io_wdata[15:8] : io_wdata[7:0];
    end

endmodule

// File: rtl/pw_ctrl_regs.sv
// Control register file for both register groups.
// Holds colour, substitute enable, rotate/operation, read plane select,
// mode, bit mask and plane enables. All reset to zero; unknown indices
// are ignored. Write takes effect from the next cycle.
module pw_ctrl_regs
    import pw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gc_we,
    input  logic [7:0] gc_sel,
    input  logic [7:0] gc_val,
    input  logic       sq_we,
    input  logic [7:0] sq_sel,
    input  logic [7:0] sq_val,
    output ctrl_regs_t regs
);

    ctrl_regs_t regs_q;

    // update graphics and sequencer registers on decoded writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            if (gc_we) begin
                case (gc_sel)
                    GIX_COLOUR: regs_q.colour   <= gc_val[NUM_PLANES-1:0];
                    GIX_SUBEN:  regs_q.sub_en   <= gc_val[NUM_PLANES-1:0];
                    GIX_ROTOP: begin
                        regs_q.rot_cnt <= gc_val[ROT_W-1:0];
                        regs_q.alu_op  <= alu_op_e'(gc_val[ROT_W+1:ROT_W]);
                    end
                    GIX_RDSEL:  regs_q.rd_plane <= gc_val[PSEL_W-1:0];
                    GIX_MODE: begin
                        regs_q.wr_mode <= gc_val[1:0];
                        regs_q.rd_mode <= gc_val[3];
                    end
                    GIX_BMASK:  regs_q.bit_mask <= gc_val;
                    default: ;
                endcase
            end
            if (sq_we && (sq_sel == SIX_PLANEN)) begin
                regs_q.plane_en <= sq_val[NUM_PLANES-1:0];
            end
        end
    end

    assign regs = regs_q;

endmodule

// File: rtl/pw_plane_alu.sv
// One plane's slice of the write datapath.
// Picks the rotated CPU byte or the substitute colour byte, applies the
// logical operation against this plane's latch, then merges by bit mask.
// Purely combinational.
module pw_plane_alu
    import pw_pkg::*;
(
    input  logic [BYTE_W-1:0] rot_byte,
    input  logic              sub_en,
    input  logic              colour,
    input  alu_op_e           alu_op,
    input  logic [BYTE_W-1:0] latch,
    input  logic [BYTE_W-1:0] bit_mask,
    output logic [BYTE_W-1:0] result
);

    logic [BYTE_W-1:0] operand;
    logic [BYTE_W-1:0] combined;

    // choose operand, apply logic op, merge with latch
    always_comb begin
        operand = sub_en ? {BYTE_W{colour}} : rot_byte;
        case (alu_op)
            ALU_AND: combined = operand & latch;
            ALU_OR:  combined = operand | latch;
            ALU_XOR: combined = operand ^ latch;
            default: combined = operand;
        endcase
        result = (combined & bit_mask) | (latch & ~bit_mask);
    end

endmodule

// File: rtl/pw_latches.sv
// Read path and plane latches.
// A read request is tracked for one cycle; in that cycle the returned plane
// bytes are valid, the selected plane goes out to the CPU, and at its end the
// four latches capture the returned bytes.
module pw_latches
    import pw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [BUS_W-1:0]  mem_rdata,
    input  logic [PSEL_W-1:0] rd_plane,
    output logic [BUS_W-1:0]  latch_q,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              cpu_rvalid
);

    logic rd_pending;

    // track the one-cycle memory read latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pending <= 1'b0;
        end else begin
            rd_pending <= rd_req;
        end
    end

    // reload all four latches when read data returns
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (rd_pending) begin
            latch_q <= mem_rdata;
        end
    end

    // return the selected plane during the data cycle
    always_comb begin
        cpu_rvalid = rd_pending;
        cpu_rdata  = rd_pending ? mem_rdata[rd_plane*BYTE_W +: BYTE_W] : '0;
    end

endmodule

// File: rtl/vga_plane_writer.sv
// Four-plane planar write datapath, top level.
// Two port decoders feed the register file; a generate loop builds one
// datapath slice per plane. CPU writes are combinational to the memory side;
// a CPU read that coincides with a write is dropped (write wins).
module vga_plane_writer
    import pw_pkg::*;
#(
    parameter int          ADDR_W      = 16,
    parameter logic [15:0] GC_IDX_PORT = 16'h03CE,
    parameter logic [15:0] GC_DAT_PORT = 16'h03CF,
    parameter logic [15:0] SQ_IDX_PORT = 16'h03C4,
    parameter logic [15:0] SQ_DAT_PORT = 16'h03C5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [15:0]       io_port,
    input  logic              io_wide,
    input  logic [15:0]       io_wdata,
    input  logic              cpu_mem_wr,
    input  logic              cpu_mem_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [3:0]        mem_we,
    output logic [31:0]       mem_wdata,
    output logic              mem_re,
    input  logic [31:0]       mem_rdata
);

    logic              gc_we, sq_we;
    logic [7:0]        gc_sel, gc_val, sq_sel, sq_val;
    ctrl_regs_t        regs;
    logic [BUS_W-1:0]  plane_latch;
    logic [BYTE_W-1:0] bit_mask;
    logic [BYTE_W-1:0] rot_byte;
    logic [BUS_W-1:0]  plane_result;
    logic              unused_mode;

    pw_port_decoder #(.IDX_PORT(GC_IDX_PORT), .DAT_PORT(GC_DAT_PORT)) u_gc_port (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port(io_port),
        .io_wide(io_wide), .io_wdata(io_wdata),
        .reg_we(gc_we), .reg_sel(gc_sel), .reg_val(gc_val)
    );

    pw_port_decoder #(.IDX_PORT(SQ_IDX_PORT), .DAT_PORT(SQ_DAT_PORT)) u_sq_port (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port(io_port),
        .io_wide(io_wide), .io_wdata(io_wdata),
        .reg_we(sq_we), .reg_sel(sq_sel), .reg_val(sq_val)
    );

    pw_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .gc_we(gc_we), .gc_sel(gc_sel), .gc_val(gc_val),
        .sq_we(sq_we), .sq_sel(sq_sel), .sq_val(sq_val),
        .regs(regs)
    );

    // stored mode fields do not steer the write path
    assign unused_mode = ^{regs.wr_mode, regs.rd_mode};
    assign bit_mask    = regs.bit_mask;

    // rotate the CPU byte right by the programmed count
    always_comb begin
        logic [2*BYTE_W-1:0] doubled;
        doubled  = {cpu_wdata, cpu_wdata} >> regs.rot_cnt;
        rot_byte = doubled[BYTE_W-1:0];
    end

    for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
        pw_plane_alu u_alu (
            .rot_byte(rot_byte),
            .sub_en(regs.sub_en[p]),
            .colour(regs.colour[p]),
            .alu_op(regs.alu_op),
            .latch(plane_latch[p*BYTE_W +: BYTE_W]),
            .bit_mask(regs.bit_mask),
            .result(plane_result[p*BYTE_W +: BYTE_W])
        );
    end

    // drive the memory-side request from the CPU access
    always_comb begin
        mem_addr  = cpu_addr;
        mem_wdata = plane_result;
        mem_we    = cpu_mem_wr ? regs.plane_en : '0;
        mem_re    = cpu_mem_rd && !cpu_mem_wr;
    end

    pw_latches u_latch (
        .clk(clk), .rst_n(rst_n), .rd_req(mem_re),
        .mem_rdata(mem_rdata), .rd_plane(regs.rd_plane),
        .latch_q(plane_latch), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid)
    );

endmodule

// File: rtl/pw_checker.sv
// Protocol and datapath properties for vga_plane_writer, bound to the top.
// Observes ports plus the latch contents and the bit mask register.
module pw_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_mem_wr,
    input logic              cpu_mem_rd,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_rvalid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [3:0]        mem_we,
    input logic [31:0]       mem_wdata,
    input logic              mem_re,
    input logic [31:0]       plane_latch,
    input logic [7:0]        bit_mask
);

    AST_STROBE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we != 4'b0) |-> cpu_mem_wr); // R7

    AST_ADDR_FOLLOWS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_mem_wr || cpu_mem_rd) |-> (mem_addr == cpu_addr)); // R7

    AST_MASKED_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_mem_wr |-> (((mem_wdata ^ plane_latch) & ~{4{bit_mask}}) == 32'h0)); // R6

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> cpu_rvalid); // R8

    AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (mem_we == 4'b0)); // R8

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rvalid |=> $stable(plane_latch)); // R8

endmodule

bind vga_plane_writer pw_checker #(.ADDR_W(ADDR_W)) u_pw_checker (
    .clk(clk), .rst_n(rst_n), .cpu_mem_wr(cpu_mem_wr), .cpu_mem_rd(cpu_mem_rd),
    .cpu_addr(cpu_addr), .cpu_rvalid(cpu_rvalid), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re),
    .plane_latch(plane_latch), .bit_mask(bit_mask)
);

// File: tb/test_vga_plane_writer.sv
module test_vga_plane_writer;

    localparam int PERIOD = 10;
    localparam logic [15:0] GI = 16'h03CE, GD = 16'h03CF;
    localparam logic [15:0] SI = 16'h03C4, SD = 16'h03C5;

    typedef struct packed {
        logic [3:0]  colour;
        logic [3:0]  sub_en;
        logic [7:0]  rotop;
        logic [7:0]  mask;
        logic [3:0]  planes;
        logic [7:0]  data;
        logic [3:0]  exp_we;
        logic [31:0] exp_wd;
    } vec_t;

    // latches hold p0=0F p1=33 p2=55 p3=F0 while the table runs
    localparam vec_t VECS [10] = '{
        '{4'h0, 4'h0, 8'h00, 8'hFF, 4'hF, 8'hA5, 4'hF, 32'hA5A5A5A5},
        '{4'h0, 4'h0, 8'h08, 8'hFF, 4'hF, 8'h3C, 4'hF, 32'h3014300C},
        '{4'h0, 4'h0, 8'h10, 8'hFF, 4'hF, 8'h3C, 4'hF, 32'hFC7D3F3F},
        '{4'h0, 4'h0, 8'h18, 8'hFF, 4'hF, 8'h3C, 4'hF, 32'hCC690F33},
        '{4'h0, 4'h0, 8'h07, 8'hFF, 4'hF, 8'h81, 4'hF, 32'h03030303},
        '{4'h0, 4'h0, 8'h04, 8'hFF, 4'hF, 8'h12, 4'hF, 32'h21212121},
        '{4'h5, 4'h3, 8'h00, 8'hFF, 4'hF, 8'h81, 4'hF, 32'h818100FF},
        '{4'h0, 4'h0, 8'h00, 8'h0F, 4'hF, 8'hAA, 4'hF, 32'hFA5A3A0A},
        '{4'h0, 4'h0, 8'h00, 8'hFF, 4'hA, 8'h77, 4'hA, 32'h77777777},
        '{4'hF, 4'h8, 8'h19, 8'hF0, 4'hF, 8'h81, 4'hF, 32'h0095F3CF}
    };

    logic        clk = 0, rst_n = 0;
    logic        io_wr = 0, io_wide = 0;
    logic [15:0] io_port = 0, io_wdata = 0;
    logic        cpu_mem_wr = 0, cpu_mem_rd = 0;
    logic [15:0] cpu_addr = 0;
    logic [7:0]  cpu_wdata = 0, cpu_rdata;
    logic        cpu_rvalid, mem_re;
    logic [15:0] mem_addr;
    logic [3:0]  mem_we;
    logic [31:0] mem_wdata, mem_rdata;
    logic [7:0]  mem_arr [4][16];
    int          errors = 0, checks = 0;
    bit          done = 0;

    vga_plane_writer i_vga_plane_writer (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_port(io_port),
        .io_wide(io_wide), .io_wdata(io_wdata), .cpu_mem_wr(cpu_mem_wr),
        .cpu_mem_rd(cpu_mem_rd), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re),
        .mem_rdata(mem_rdata)
    );

    always #(PERIOD/2) clk = ~clk;

    // plane memory model: byte writes per plane, one-cycle read
    always @(posedge clk) begin
        for (int p = 0; p < 4; p++)
            if (mem_we[p]) mem_arr[p][mem_addr[3:0]] <= mem_wdata[p*8 +: 8];
        if (mem_re)
            mem_rdata <= {mem_arr[3][mem_addr[3:0]], mem_arr[2][mem_addr[3:0]],
                          mem_arr[1][mem_addr[3:0]], mem_arr[0][mem_addr[3:0]]};
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic io_put(input logic [15:0] port, input logic [15:0] data, input bit wide);
        @(negedge clk);
        io_wr = 1; io_port = port; io_wdata = data; io_wide = wide;
        @(negedge clk);
        io_wr = 0; io_wide = 0;
    endtask

    task automatic set_reg(input bit seq, input logic [7:0] idx, input logic [7:0] val, input bit wide);
        if (wide) io_put(seq ? SI : GI, {val, idx}, 1);
        else begin
            io_put(seq ? SI : GI, {8'h00, idx}, 0);
            io_put(seq ? SD : GD, {8'h00, val}, 0);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d,
                             output logic [3:0] we, output logic [31:0] wd);
        @(negedge clk);
        cpu_mem_wr = 1; cpu_addr = a; cpu_wdata = d;
        #1 we = mem_we; wd = mem_wdata;
        @(negedge clk);
        cpu_mem_wr = 0;
    endtask

    task automatic cpu_read(input logic [15:0] a, output logic [7:0] d, output logic v);
        @(negedge clk);
        cpu_mem_rd = 1; cpu_addr = a;
        @(negedge clk);
        cpu_mem_rd = 0;
        #1 d = cpu_rdata; v = cpu_rvalid;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [3:0]  we;
        logic [31:0] wd;
        logic [7:0]  rd;
        logic        rv;
        for (int p = 0; p < 4; p++)
            for (int a = 0; a < 16; a++) mem_arr[p][a] = 8'h00;
        mem_rdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk("R1 reset rvalid", {31'h0, cpu_rvalid}, 32'h0);
        chk("R1 reset strobes", {28'h0, mem_we}, 32'h0);

        // zero registers: no strobes
        cpu_write(16'h1, 8'h5A, we, wd);
        chk("R1 no strobe when planes disabled", {28'h0, we}, 32'h0);
        // planes on, mask zero: latch (zero) wins
        set_reg(1, 8'd2, 8'h0F, 1);
        cpu_write(16'h1, 8'h5A, we, wd);
        chk("R1 R6 zero mask keeps zero latch", wd, 32'h0);
        set_reg(0, 8'd8, 8'hFF, 0);
        cpu_write(16'h1, 8'h5A, we, wd);
        chk("R1 strobes", {28'h0, we}, 32'hF);
        chk("R1 unchanged byte", wd, 32'h5A5A5A5A);

        // R2: wide index write leaves index for data-port byte
        io_put(GI, {8'hFF, 8'h08}, 1);
        io_put(GD, 16'h000F, 0);
        cpu_write(16'h1, 8'hFF, we, wd);
        chk("R2 index kept after wide write", wd, 32'h0F0F0F0F);
        set_reg(0, 8'd8, 8'hFF, 1);

        // preload address 3 one plane at a time
        set_reg(1, 8'd2, 8'h01, 0); cpu_write(16'h3, 8'h0F, we, wd);
        set_reg(1, 8'd2, 8'h02, 1); cpu_write(16'h3, 8'h33, we, wd);
        set_reg(1, 8'd2, 8'h04, 0); cpu_write(16'h3, 8'h55, we, wd);
        set_reg(1, 8'd2, 8'h08, 1); cpu_write(16'h3, 8'hF0, we, wd);
        chk("R7 single plane strobe", {28'h0, we}, 32'h8);

        // R8: read plane select and latency
        set_reg(0, 8'd4, 8'h02, 0);
        cpu_read(16'h3, rd, rv);
        chk("R8 rvalid after one cycle", {31'h0, rv}, 32'h1);
        chk("R8 plane 2 data", {24'h0, rd}, 32'h55);
        set_reg(0, 8'd4, 8'h03, 1);
        cpu_read(16'h3, rd, rv);
        chk("R8 plane 3 data", {24'h0, rd}, 32'hF0);

        // table: rotate, substitute, logic op, mask, plane enables
        for (int i = 0; i < 10; i++) begin
            bit w;
            w = i[0];
            set_reg(0, 8'd0, {4'h0, VECS[i].colour}, w);
            set_reg(0, 8'd1, {4'h0, VECS[i].sub_en}, !w);
            set_reg(0, 8'd3, VECS[i].rotop, w);
            set_reg(0, 8'd8, VECS[i].mask, !w);
            set_reg(1, 8'd2, {4'h0, VECS[i].planes}, w);
            cpu_write(16'h8, VECS[i].data, we, wd);
            chk($sformatf("R3 R4 R5 R6 R2 vector %0d data", i), wd, VECS[i].exp_wd);
            chk($sformatf("R7 R2 vector %0d strobes", i), {28'h0, we}, {28'h0, VECS[i].exp_we});
        end

        // R9: write mode field does not alter processing
        set_reg(0, 8'd0, 8'h00, 0); set_reg(0, 8'd1, 8'h00, 0);
        set_reg(0, 8'd3, 8'h00, 1); set_reg(0, 8'd8, 8'hFF, 1);
        set_reg(1, 8'd2, 8'h0F, 0);
        set_reg(0, 8'd5, 8'h0B, 1);
        cpu_write(16'h9, 8'hC3, we, wd);
        chk("R9 mode ignored by write path", wd, 32'hC3C3C3C3);

        // R10: unassigned indices change nothing
        set_reg(0, 8'd9, 8'h00, 1);
        set_reg(0, 8'd2, 8'h00, 0);
        set_reg(1, 8'd3, 8'h00, 1);
        cpu_write(16'h9, 8'h3C, we, wd);
        chk("R10 mask unchanged", wd, 32'h3C3C3C3C);
        chk("R10 plane enables unchanged", {28'h0, we}, 32'hF);

        // R8: latches reloaded by read; zero mask copies them out
        set_reg(0, 8'd8, 8'h00, 0);
        cpu_read(16'h3, rd, rv);
        cpu_write(16'hA, 8'hFF, we, wd);
        chk("R8 latches reloaded", wd, 32'hF055330F);

        finish_run();
    end

endmodule